// File: doc/BRIEF.md
# Single-Cycle Word Machine Core

This block is a compact 32-bit processor that executes a reduced load/store instruction set. It completes one instruction on every clock after reset. It reads instructions through a word-indexed port and accesses data through a second word-indexed port. Both memories sit outside the core. The core holds 32 general registers, a program counter, two constant product registers that read as zero, and a retired-instruction counter. There are no delay slots, no pipeline, no exceptions and no multiplier.

The core's control is a two-state machine. `ST_RUN` is the state after reset. In it, the instruction at the program counter is decoded and executed, and its results are committed on the clock edge. The transition `RUN_TO_HALT` is taken when the next program counter that an instruction produces is zero, and the core then enters `ST_HALT`. The transition `HALT_HOLD` keeps the core in `ST_HALT` until reset. In `ST_HALT` nothing is committed and the `halted` output is high. A program ends by jumping through register 0, or by reaching an encoding that is not defined.

An instruction is one 32-bit word. The major code sits in bits 31:26. For the register format (major code 0), the sub-code is in bits 5:0, the shift distance in 10:6, the destination in 15:11, the second source in 20:16 and the first source in 25:21. For the immediate format, the first source is in 25:21, the target register is in 20:16 and the 16-bit constant is in 15:0. The jump format has a 26-bit word target in bits 25:0.

Top module: `sqc_core`

## Requirements
- R1: While reset is held and right after its release, `pc_o` is 0x00400000, `retired` is 0 and `halted` is low. Every register starts at 0, except register 29, which starts at 0x7FFFEFFC.
- R2: Fetch and data accesses use address bits 7:2 as the word index and ignore all other address bits. Byte addresses 0x104 and 0x204 both reach data word 1, and program counter 0x140 fetches instruction word 16.
- R3: Register-format operations give the following results in rd. Sub-code 33 gives rs+rt, 35 gives rs−rt, 36 gives AND, 37 gives OR and 38 gives XOR. Sub-code 42 gives 1 if rs<rt as signed values, else 0. Sub-code 43 gives the same comparison on unsigned values.
- R4: Shifts are logical and write rd. Sub-code 0 gives rt<<shamt and 2 gives rt>>shamt. Sub-code 4 gives rt<<rs[4:0] and 6 gives rt>>rs[4:0].
- R5: Immediate operations write the rt field. Code 9 adds the sign-extended constant. Code 12 ANDs, 13 ORs and 14 XORs with the zero-extended constant. Code 10 compares signed and code 11 compares unsigned, both against the sign-extended constant. Code 15 places the constant in bits 31:16 and zeros the low half.
- R6: Code 35 loads the data word at rs+sext(imm) into rt. Code 43 stores rt to that word, and `dmem_we` is high only during that instruction.
- R7: Conditional branches have no delay slot. Code 4 branches when rs==rt, code 5 when rs!=rt, and code 1 when rs is not negative (the rt field is ignored). A taken branch goes to the branch's own address plus sext(imm)×4, backward targets included. When not taken, execution goes to the following word.
- R8: Code 2 jumps to {4'b0, target, 2'b00}. Code 3 does the same and also writes the branch's own address + 4 into register 31. Register sub-code 8 jumps to the address held in rs.
- R9: Writes to register 0 are discarded, so it always reads 0. Sub-codes 16 and 18 write 0 to rd, because the product registers are never loaded.
- R10: Any major code or register sub-code not listed sets the next program counter to 0. The core halts at once, and no later instruction executes.
- R11: `halted` rises on the clock edge that commits an instruction whose next program counter is 0, and `pc_o` is then 0. After that `halted` stays high, and `retired`, `pc_o` and data memory stay unchanged.
- R12: `retired` counts committed instructions, the halting one included. It advances by exactly one on every clock in `ST_RUN`, so a program of N executed instructions halts N clocks after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_idx | output | MEM_AW | Instruction word index (program counter bits 7:2) |
| imem_rdata | input | 32 | Instruction word at `imem_idx`, combinational |
| dmem_idx | output | MEM_AW | Data word index for load and store |
| dmem_rdata | input | 32 | Data word at `dmem_idx`, combinational |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store enable, sampled by memory on the rising edge |
| pc_o | output | 32 | Address of the instruction being executed |
| halted | output | 1 | High in `ST_HALT` |
| retired | output | CNT_W | Committed instruction count |

## Verification
The bench sweeps every arithmetic, logic, shift, compare and immediate operation over operand pairs chosen to hit the sign boundary, all-ones values and shift amounts above 15. This catches an arithmetic shift used where a logical one belongs, and zero-extension used where sign-extension belongs. A compare with the wrong signedness flips its result on the 0x80000000/0x7FFFFFFF pair. A core that lets register 0 take a write stores a non-zero sum, and one that resets register 29 wrongly exposes a bad stack value. An exchange sort runs over several arrays and checks the sorted data and the exact count of executed instructions, which depends on how many swaps occur. An off-by-one branch base, a missing link, or an executed delay slot changes that count. Further programs exercise backward loops, skipped stores behind taken branches, address aliasing above bit 7, and halts from undefined codes. After each halt the bench checks that no store follows and that the counter stops.

// File: rtl/sqc_pkg.sv
package sqc_pkg;

    localparam int XLEN   = 32;
    localparam int REG_IW = 5;

    // major codes
    localparam logic [5:0] MC_REG   = 6'd0;
    localparam logic [5:0] MC_BGEZ  = 6'd1;
    localparam logic [5:0] MC_J     = 6'd2;
    localparam logic [5:0] MC_JAL   = 6'd3;
    localparam logic [5:0] MC_BEQ   = 6'd4;
    localparam logic [5:0] MC_BNE   = 6'd5;
    localparam logic [5:0] MC_ADDIU = 6'd9;
    localparam logic [5:0] MC_SLTI  = 6'd10;
    localparam logic [5:0] MC_SLTIU = 6'd11;
    localparam logic [5:0] MC_ANDI  = 6'd12;
    localparam logic [5:0] MC_ORI   = 6'd13;
    localparam logic [5:0] MC_XORI  = 6'd14;
    localparam logic [5:0] MC_LUI   = 6'd15;
    localparam logic [5:0] MC_LW    = 6'd35;
    localparam logic [5:0] MC_SW    = 6'd43;

    // register-format sub-codes
    localparam logic [5:0] SC_SLL  = 6'd0;
    localparam logic [5:0] SC_SRL  = 6'd2;
    localparam logic [5:0] SC_SLLV = 6'd4;
    localparam logic [5:0] SC_SRLV = 6'd6;
    localparam logic [5:0] SC_JR   = 6'd8;
    localparam logic [5:0] SC_MFHI = 6'd16;
    localparam logic [5:0] SC_MFLO = 6'd18;
    localparam logic [5:0] SC_ADDU = 6'd33;
    localparam logic [5:0] SC_SUBU = 6'd35;
    localparam logic [5:0] SC_AND  = 6'd36;
    localparam logic [5:0] SC_OR   = 6'd37;
    localparam logic [5:0] SC_XOR  = 6'd38;
    localparam logic [5:0] SC_SLT  = 6'd42;
    localparam logic [5:0] SC_SLTU = 6'd43;

    typedef enum logic [4:0] {
        OP_ADDU, OP_SUBU, OP_AND, OP_OR, OP_XOR,
        OP_SLL, OP_SRL, OP_SLLV, OP_SRLV,
        OP_SLT, OP_SLTU, OP_JR, OP_MFHI, OP_MFLO,
        OP_J, OP_JAL,
        OP_ADDIU, OP_ANDI, OP_ORI, OP_XORI,
        OP_LW, OP_SW, OP_LUI,
        OP_BEQ, OP_BNE, OP_BGEZ,
        OP_SLTI, OP_SLTIU,
        OP_BAD
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [REG_IW-1:0] rs;
        logic [REG_IW-1:0] rt;
        logic [REG_IW-1:0] rd;
        logic [4:0]        shamt;
        logic [15:0]       imm;
        logic [25:0]       tgt;
    } dec_t;

    typedef enum logic [0:0] {
        ST_RUN,
        ST_HALT
    } core_st_e;

endpackage

// File: rtl/sqc_decode.sv
module sqc_decode
    import sqc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);

    logic [5:0] major;
    logic [5:0] sub;

    assign major = instr[31:26];
    assign sub   = instr[5:0];

    always_comb begin
        dec.rs    = instr[25:21];
        dec.rt    = instr[20:16];
        dec.rd    = instr[15:11];
        dec.shamt = instr[10:6];
        dec.imm   = instr[15:0];
        dec.tgt   = instr[25:0];
        dec.op    = OP_BAD;
        if (major == MC_REG) begin
            unique case (sub)
                SC_ADDU: dec.op = OP_ADDU;
                SC_SUBU: dec.op = OP_SUBU;
                SC_AND:  dec.op = OP_AND;
                SC_OR:   dec.op = OP_OR;
                SC_XOR:  dec.op = OP_XOR;
                SC_SLL:  dec.op = OP_SLL;
                SC_SRL:  dec.op = OP_SRL;
                SC_SLLV: dec.op = OP_SLLV;
                SC_SRLV: dec.op = OP_SRLV;
                SC_SLT:  dec.op = OP_SLT;
                SC_SLTU: dec.op = OP_SLTU;
                SC_JR:   dec.op = OP_JR;
                SC_MFHI: dec.op = OP_MFHI;
                SC_MFLO: dec.op = OP_MFLO;
                default: dec.op = OP_BAD;
            endcase
        end else begin
            unique case (major)
                MC_J:     dec.op = OP_J;
                MC_JAL:   dec.op = OP_JAL;
                MC_ADDIU: dec.op = OP_ADDIU;
                MC_ANDI:  dec.op = OP_ANDI;
                MC_ORI:   dec.op = OP_ORI;
                MC_XORI:  dec.op = OP_XORI;
                MC_LW:    dec.op = OP_LW;
                MC_SW:    dec.op = OP_SW;
                MC_LUI:   dec.op = OP_LUI;
                MC_BEQ:   dec.op = OP_BEQ;
                MC_BNE:   dec.op = OP_BNE;
                MC_BGEZ:  dec.op = OP_BGEZ;
                MC_SLTI:  dec.op = OP_SLTI;
                MC_SLTIU: dec.op = OP_SLTIU;
                default:  dec.op = OP_BAD;
            endcase
        end
    end

endmodule

// File: rtl/sqc_regfile.sv
module sqc_regfile
    import sqc_pkg::*;
#(
    parameter int               NREGS   = 32,
    parameter int               SP_IDX  = 29,
    parameter logic [XLEN-1:0]  SP_INIT = 32'h7FFF_EFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_IW-1:0] ra_idx,
    output logic [XLEN-1:0]   ra_val,
    input  logic [REG_IW-1:0] rb_idx,
    output logic [XLEN-1:0]   rb_val,
    input  logic              we,
    input  logic [REG_IW-1:0] w_idx,
    input  logic [XLEN-1:0]   w_val
);

    logic [XLEN-1:0] regs [NREGS];

    // register 0 is never written, so it keeps its reset value of zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs[i] <= (i == SP_IDX) ? SP_INIT : '0;
            end
        end else if (we && (w_idx != '0)) begin
            regs[w_idx] <= w_val;
        end
    end

    assign ra_val = regs[ra_idx];
    assign rb_val = regs[rb_idx];

endmodule

// File: rtl/sqc_exec.sv
module sqc_exec
    import sqc_pkg::*;
#(
    parameter int MEM_AW   = 6,
    parameter int LINK_IDX = 31
) (
    input  dec_t              dec,
    input  logic [XLEN-1:0]   rs_val,
    input  logic [XLEN-1:0]   rt_val,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   hi_val,
    input  logic [XLEN-1:0]   lo_val,
    input  logic [XLEN-1:0]   ld_data,
    output logic              wr_en,
    output logic [REG_IW-1:0] wr_idx,
    output logic [XLEN-1:0]   wr_data,
    output logic [XLEN-1:0]   next_pc,
    output logic              st_en,
    output logic [MEM_AW-1:0] mem_idx,
    output logic [XLEN-1:0]   st_data
);

    logic [XLEN-1:0] imm_s;
    logic [XLEN-1:0] imm_z;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] br_tgt;

    assign imm_s    = {{(XLEN-16){dec.imm[15]}}, dec.imm};
    assign imm_z    = {{(XLEN-16){1'b0}}, dec.imm};
    assign pc_plus4 = pc + XLEN'(4);
    assign br_tgt   = pc + (imm_s << 2);
    assign mem_idx  = MEM_AW'((rs_val + imm_s) >> 2);
    assign st_data  = rt_val;

    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = dec.rd;
        wr_data = '0;
        next_pc = pc_plus4;
        st_en   = 1'b0;
        unique case (dec.op)
            OP_ADDU:  begin wr_en = 1'b1; wr_data = rs_val + rt_val; end
            OP_SUBU:  begin wr_en = 1'b1; wr_data = rs_val - rt_val; end
            OP_AND:   begin wr_en = 1'b1; wr_data = rs_val & rt_val; end
            OP_OR:    begin wr_en = 1'b1; wr_data = rs_val | rt_val; end
            OP_XOR:   begin wr_en = 1'b1; wr_data = rs_val ^ rt_val; end
            OP_SLL:   begin wr_en = 1'b1; wr_data = rt_val << dec.shamt; end
            OP_SRL:   begin wr_en = 1'b1; wr_data = rt_val >> dec.shamt; end
            OP_SLLV:  begin wr_en = 1'b1; wr_data = rt_val << rs_val[4:0]; end
            OP_SRLV:  begin wr_en = 1'b1; wr_data = rt_val >> rs_val[4:0]; end
            OP_SLT:   begin
                wr_en   = 1'b1;
                wr_data = XLEN'($signed(rs_val) < $signed(rt_val));
            end
            OP_SLTU:  begin wr_en = 1'b1; wr_data = XLEN'(rs_val < rt_val); end
            OP_JR:    next_pc = rs_val;
            OP_MFHI:  begin wr_en = 1'b1; wr_data = hi_val; end
            OP_MFLO:  begin wr_en = 1'b1; wr_data = lo_val; end
            OP_J:     next_pc = {4'b0, dec.tgt, 2'b00};
            OP_JAL:   begin
                next_pc = {4'b0, dec.tgt, 2'b00};
                wr_en   = 1'b1;
                wr_idx  = REG_IW'(LINK_IDX);
                wr_data = pc_plus4;
            end
            OP_ADDIU: begin wr_en = 1'b1; wr_idx = dec.rt; wr_data = rs_val + imm_s; end
            OP_ANDI:  begin wr_en = 1'b1; wr_idx = dec.rt; wr_data = rs_val & imm_z; end
            OP_ORI:   begin wr_en = 1'b1; wr_idx = dec.rt; wr_data = rs_val | imm_z; end
            OP_XORI:  begin wr_en = 1'b1; wr_idx = dec.rt; wr_data = rs_val ^ imm_z; end
            OP_LW:    begin wr_en = 1'b1; wr_idx = dec.rt; wr_data = ld_data; end
            OP_SW:    st_en = 1'b1;
            OP_LUI:   begin wr_en = 1'b1; wr_idx = dec.rt; wr_data = {dec.imm, 16'h0000}; end
            OP_BEQ:   if (rs_val == rt_val) next_pc = br_tgt;
            OP_BNE:   if (rs_val != rt_val) next_pc = br_tgt;
            OP_BGEZ:  if (!rs_val[XLEN-1]) next_pc = br_tgt;
            OP_SLTI:  begin
                wr_en   = 1'b1;
                wr_idx  = dec.rt;
                wr_data = XLEN'($signed(rs_val) < $signed(imm_s));
            end
            OP_SLTIU: begin
                wr_en   = 1'b1;
                wr_idx  = dec.rt;
                wr_data = XLEN'(rs_val < imm_s);
            end
            default:  next_pc = '0;
        endcase
    end

endmodule

// File: rtl/sqc_core.sv
module sqc_core
    import sqc_pkg::*;
#(
    parameter int              MEM_AW   = 6,
    parameter int              CNT_W    = 32,
    parameter logic [31:0]     RESET_PC = 32'h0040_0000,
    parameter logic [31:0]     SP_INIT  = 32'h7FFF_EFFC,
    parameter int              SP_IDX   = 29,
    parameter int              NREGS    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [MEM_AW-1:0] imem_idx,
    input  logic [31:0]       imem_rdata,
    output logic [MEM_AW-1:0] dmem_idx,
    input  logic [31:0]       dmem_rdata,
    output logic [31:0]       dmem_wdata,
    output logic              dmem_we,
    output logic [31:0]       pc_o,
    output logic              halted,
    output logic [CNT_W-1:0]  retired
);

    localparam int LINK_IDX = NREGS - 1;

    core_st_e          st_q, st_d;
    logic [XLEN-1:0]   pc_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [XLEN-1:0]   hi_q, lo_q;
    logic              commit;
    dec_t              dec;
    logic [XLEN-1:0]   rs_val, rt_val;
    logic              wr_en, st_en, rf_we;
    logic [REG_IW-1:0] wr_idx;
    logic [XLEN-1:0]   wr_data, next_pc;

    sqc_decode i_dec (
        .instr (imem_rdata),
        .dec   (dec)
    );

    sqc_regfile #(
        .NREGS   (NREGS),
        .SP_IDX  (SP_IDX),
        .SP_INIT (SP_INIT)
    ) i_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (dec.rs),
        .ra_val (rs_val),
        .rb_idx (dec.rt),
        .rb_val (rt_val),
        .we     (rf_we),
        .w_idx  (wr_idx),
        .w_val  (wr_data)
    );

    sqc_exec #(
        .MEM_AW   (MEM_AW),
        .LINK_IDX (LINK_IDX)
    ) i_exec (
        .dec     (dec),
        .rs_val  (rs_val),
        .rt_val  (rt_val),
        .pc      (pc_q),
        .hi_val  (hi_q),
        .lo_val  (lo_q),
        .ld_data (dmem_rdata),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .next_pc (next_pc),
        .st_en   (st_en),
        .mem_idx (dmem_idx),
        .st_data (dmem_wdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // next state and outputs
    always_comb begin
        st_d    = st_q;
        commit  = 1'b0;
        halted  = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                commit = rst_n;
                if (next_pc == '0) st_d = ST_HALT;   // RUN_TO_HALT
            end
            ST_HALT: begin
                halted = 1'b1;
                st_d   = ST_HALT;                    // HALT_HOLD
            end
            default: st_d = ST_HALT;
        endcase
        rf_we   = commit && wr_en;
        dmem_we = commit && st_en;
    end

    // program counter, retire counter, constant product registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= RESET_PC;
            cnt_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else if (commit) begin
            pc_q  <= next_pc;
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign imem_idx = MEM_AW'(pc_q >> 2);
    assign pc_o     = pc_q;
    assign retired  = cnt_q;

endmodule

// File: rtl/sqc_core_chk.sv
module sqc_core_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halted,
    input logic             dmem_we,
    input logic [31:0]      pc_o,
    input logic [CNT_W-1:0] retired
);

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);                                              // R11

    AST_HALT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !dmem_we);                                            // R11

    AST_HALT_PC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (pc_o == 32'h0));                                     // R10

    AST_HALT_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(retired) && $stable(pc_o));                   // R11

    AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |=> (retired == $past(retired) + CNT_W'(1)));            // R12

endmodule

bind sqc_core sqc_core_chk #(.CNT_W(CNT_W)) i_sqc_core_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .halted  (halted),
    .dmem_we (dmem_we),
    .pc_o    (pc_o),
    .retired (retired)
);

// File: tb/test_sqc_core.sv
module test_sqc_core;

    localparam int MEM_AW = 6;
    localparam int MW     = 1 << MEM_AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [MEM_AW-1:0] imem_idx, dmem_idx;
    logic [31:0]       imem_rdata, dmem_rdata, dmem_wdata, pc_o;
    logic              dmem_we, halted;
    logic [31:0]       retired;

    logic [31:0] imem [MW];
    logic [31:0] dmem [MW];
    int n_chk = 0;
    int n_err = 0;
    int wp = 0;

    always #10 clk = ~clk;

    sqc_core i_sqc_core (
        .clk(clk), .rst_n(rst_n),
        .imem_idx(imem_idx), .imem_rdata(imem_rdata),
        .dmem_idx(dmem_idx), .dmem_rdata(dmem_rdata),
        .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .pc_o(pc_o), .halted(halted), .retired(retired)
    );

    assign imem_rdata = imem[imem_idx];
    assign dmem_rdata = dmem[dmem_idx];
    always @(posedge clk) if (dmem_we) dmem[dmem_idx] <= dmem_wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(int fn, int rs, int rt, int rd, int sh);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
    endfunction
    function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
        return {op[5:0], rs[4:0], rt[4:0], imm};
    endfunction
    function automatic logic [31:0] enc_j(int op, int word);
        logic [31:0] t = 32'h0010_0000 + word;
        return {op[5:0], t[25:0]};
    endfunction

    task automatic emit(input logic [31:0] w);
        imem[wp] = w;
        wp++;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MW; i++) begin
            imem[i] = 32'hFFFF_FFFF;
            dmem[i] = 32'hA5A5_0000 | i;
        end
        wp = 0;
    endtask

    task automatic run_prog(input string req, input int exp_n, input bit chk_reset);
        int cyc = 0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        if (chk_reset) begin
            chk("R1 reset pc", pc_o, 32'h0040_0000);
            chk("R1 reset retired", retired, 0);
            chk("R1 reset halted", {31'b0, halted}, 0);
        end
        rst_n = 1'b1;
        if (chk_reset) chk("R1 pc after release", pc_o, 32'h0040_0000);
        while (!halted && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk({req, " R11 halted"}, {31'b0, halted}, 1);
        chk({req, " R12 retired"}, retired, exp_n);
        chk({req, " R12 clocks"}, cyc, exp_n);
        chk({req, " R11 pc zero"}, pc_o, 0);
        repeat (4) @(negedge clk);
        chk({req, " R11 frozen count"}, retired, exp_n);
        chk({req, " R11 still halted"}, {31'b0, halted}, 1);
    endtask

    function automatic logic [31:0] alu_exp(int k, logic [31:0] a, logic [31:0] b);
        logic [31:0] se = {{16{b[15]}}, b[15:0]};
        logic [31:0] ze = {16'h0, b[15:0]};
        case (k)
            0:  return a + b;
            1:  return a - b;
            2:  return a & b;
            3:  return a | b;
            4:  return a ^ b;
            5:  return {31'b0, $signed(a) < $signed(b)};
            6:  return {31'b0, a < b};
            7:  return b << a[4:0];
            8:  return b >> a[4:0];
            9:  return b << 7;
            10: return b >> 13;
            11: return a + se;
            12: return a & ze;
            13: return a | ze;
            14: return a ^ ze;
            15: return {31'b0, $signed(a) < $signed(se)};
            16: return {31'b0, a < se};
            17: return {b[15:0], 16'h0};
            21: return 32'h7FFF_EFFC;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string alu_req(int k);
        if (k <= 6) return "R3";
        if (k <= 10) return "R4";
        if (k <= 17) return "R5";
        if (k == 21) return "R1";
        return "R9";
    endfunction

    task automatic alu_pair(input logic [31:0] a, input logic [31:0] b);
        logic [15:0] im = b[15:0];
        clear_mem();
        emit(enc_i(15, 0, 1, a[31:16]));
        emit(enc_i(13, 1, 1, a[15:0]));
        emit(enc_i(15, 0, 2, b[31:16]));
        emit(enc_i(13, 2, 2, b[15:0]));
        for (int k = 0; k < 23; k++) begin
            int src = 3;
            case (k)
                0:  emit(enc_r(33, 1, 2, 3, 0));
                1:  emit(enc_r(35, 1, 2, 3, 0));
                2:  emit(enc_r(36, 1, 2, 3, 0));
                3:  emit(enc_r(37, 1, 2, 3, 0));
                4:  emit(enc_r(38, 1, 2, 3, 0));
                5:  emit(enc_r(42, 1, 2, 3, 0));
                6:  emit(enc_r(43, 1, 2, 3, 0));
                7:  emit(enc_r(4, 1, 2, 3, 0));
                8:  emit(enc_r(6, 1, 2, 3, 0));
                9:  emit(enc_r(0, 0, 2, 3, 7));
                10: emit(enc_r(2, 0, 2, 3, 13));
                11: emit(enc_i(9, 1, 3, im));
                12: emit(enc_i(12, 1, 3, im));
                13: emit(enc_i(13, 1, 3, im));
                14: emit(enc_i(14, 1, 3, im));
                15: emit(enc_i(10, 1, 3, im));
                16: emit(enc_i(11, 1, 3, im));
                17: emit(enc_i(15, 0, 3, im));
                18: emit(enc_r(16, 0, 0, 3, 0));
                19: emit(enc_r(18, 0, 0, 3, 0));
                20: begin emit(enc_r(33, 1, 2, 0, 0)); src = 0; end
                21: src = 29;
                default: src = 5;
            endcase
            emit(enc_i(43, 0, src, 16'(4 * k)));
        end
        emit(enc_r(8, 0, 0, 0, 0));
        run_prog("alu", wp, 1'b0);
        for (int k = 0; k < 23; k++)
            chk($sformatf("%s op%0d a=%h b=%h", alu_req(k), k, a, b), dmem[k], alu_exp(k, a, b));
    endtask

    task automatic sort_run(input logic [31:0] arr [8]);
        int w [8];
        int swaps = 0;
        clear_mem();
        for (int i = 0; i < 8; i++) begin
            w[i] = arr[i];
            dmem[i] = arr[i];
        end
        for (int i = 0; i < 7; i++)
            for (int j = i + 1; j < 8; j++)
                if (w[j] < w[i]) begin
                    int t = w[i];
                    w[i] = w[j];
                    w[j] = t;
                    swaps++;
                end
        emit(enc_i(9, 0, 16, 16'd0));
        emit(enc_i(10, 16, 8, 16'd7));
        emit(enc_i(4, 8, 0, 16'd9));
        emit(enc_i(9, 16, 17, 16'd1));
        emit(enc_i(10, 17, 8, 16'd8));
        emit(enc_i(4, 8, 0, 16'd4));
        emit(enc_j(3, 12));
        emit(enc_i(9, 17, 17, 16'd1));
        emit(enc_j(2, 4));
        emit(enc_i(9, 16, 16, 16'd1));
        emit(enc_j(2, 1));
        emit(enc_r(8, 0, 0, 0, 0));
        emit(enc_r(0, 0, 16, 9, 2));
        emit(enc_i(35, 9, 10, 16'd0));
        emit(enc_r(0, 0, 17, 11, 2));
        emit(enc_i(35, 11, 12, 16'd0));
        emit(enc_r(42, 12, 10, 13, 0));
        emit(enc_i(4, 13, 0, 16'd3));
        emit(enc_i(43, 9, 12, 16'd0));
        emit(enc_i(43, 11, 10, 16'd0));
        emit(enc_r(8, 31, 0, 0, 0));
        // R7 R8: count depends on branch base, link and swap count
        run_prog("R7 R8 sort", 389 + 2 * swaps, 1'b0);
        for (int i = 0; i < 8; i++)
            chk($sformatf("R6 sorted word %0d", i), dmem[i], w[i]);
    endtask

    initial begin : main
        logic [31:0] pa [8] = '{32'h0, 32'h1, 32'h8000_0000, 32'h1234_5678,
                               32'hFFFF_FFFB, 32'hDEAD_BEEF, 32'h7FFF_FFFF, 32'h0000_001F};
        logic [31:0] pb [8] = '{32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h0000_F00D,
                               32'h0000_0003, 32'h0000_001F, 32'h8000_8000, 32'h8000_0001};
        logic [31:0] s0 [8] = '{40, -3, 7, 7, 0, -128, 15, 2};
        logic [31:0] s1 [8] = '{0, 1, 2, 3, 4, 5, 6, 7};
        logic [31:0] s2 [8] = '{7, 6, 5, 4, 3, 2, 1, 0};
        logic [31:0] s3 [8] = '{32'h7FFF_FFFF, 32'h8000_0000, -1, 1, 0, 32'h8000_0000, 5, -1};

        // R1 reset state; R10 undefined major code, R2 aliasing
        clear_mem();
        imem[0]  = enc_i(9, 0, 1, 16'd5);
        imem[1]  = enc_i(43, 0, 1, 16'h0104);
        imem[2]  = enc_i(35, 0, 3, 16'h0204);
        imem[3]  = enc_i(43, 0, 3, 16'd8);
        imem[4]  = {6'd2, 26'h50};
        imem[5]  = enc_i(43, 0, 1, 16'd12);
        imem[16] = enc_i(43, 0, 1, 16'd16);
        imem[17] = {6'd63, 26'h0};
        imem[18] = enc_i(43, 0, 1, 16'd20);
        run_prog("R10 R2 alias", 7, 1'b1);
        chk("R2 store 0x104 to word 1", dmem[1], 5);
        chk("R2 load 0x204 from word 1", dmem[2], 5);
        chk("R8 jump skips word 5", dmem[3], 32'hA5A5_0003);
        chk("R2 fetch 0x140 runs word 16", dmem[4], 5);
        chk("R10 no execution after bad code", dmem[5], 32'hA5A5_0005);

        // R10 undefined register sub-code
        clear_mem();
        imem[0] = enc_i(9, 0, 1, 16'd9);
        imem[1] = enc_r(1, 0, 0, 0, 0);
        imem[2] = enc_i(43, 0, 1, 16'd0);
        run_prog("R10 bad sub-code", 2, 1'b0);
        chk("R10 store after bad sub-code", dmem[0], 32'hA5A5_0000);

        // R7 branches, backward loop; R8 link
        clear_mem();
        imem[0]  = enc_i(9, 0, 1, 16'hFFFF);
        imem[1]  = enc_i(1, 1, 1, 16'd3);
        imem[2]  = enc_i(43, 0, 1, 16'd0);
        imem[3]  = enc_i(9, 0, 2, 16'd7);
        imem[4]  = enc_i(5, 2, 0, 16'd2);
        imem[5]  = enc_i(43, 0, 2, 16'd4);
        imem[6]  = enc_i(1, 2, 1, 16'd2);
        imem[7]  = enc_i(43, 0, 2, 16'd8);
        imem[8]  = enc_i(4, 2, 0, 16'd2);
        imem[9]  = enc_i(9, 2, 2, 16'hFFFF);
        imem[10] = enc_i(5, 2, 0, 16'hFFFF);
        imem[11] = enc_i(43, 0, 2, 16'd12);
        imem[12] = enc_j(3, 15);
        imem[13] = enc_i(43, 0, 31, 16'd16);
        imem[14] = enc_r(8, 0, 0, 0, 0);
        imem[15] = enc_r(8, 31, 0, 0, 0);
        run_prog("R7 branch", 26, 1'b0);
        chk("R7 untaken branch falls through", dmem[0], 32'hFFFF_FFFF);
        chk("R7 taken bne skips store", dmem[1], 32'hA5A5_0001);
        chk("R7 taken bgez skips store", dmem[2], 32'hA5A5_0002);
        chk("R7 backward loop result", dmem[3], 0);
        chk("R8 link value", dmem[4], 32'h0040_0034);

        // R3 R4 R5 R9 operation sweep
        for (int p = 0; p < 8; p++) alu_pair(pa[p], pb[p]);

        // R6 R7 R8 exchange sort over several arrays
        sort_run(s0);
        sort_run(s1);
        sort_run(s2);
        sort_run(s3);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule